// File: doc/BRIEF.md
# Iterative Half-Adder Adder

This block adds two unsigned operands of `WIDTH` bits (16 by default) without any carry-propagate chain. It holds a working pair of words, each `WIDTH+1` bits wide, in enabled registers. Every pass through a single row of half-adders replaces the pair with their bitwise sum and their carry word moved up one bit. When the carry word becomes zero, the first word holds the full `WIDTH+1`-bit result.

A four-state controller sequences the work: wait for a request, test the carry word, run a half-adder pass, and report the result. The number of passes depends on the operands. The block reports that number with each result, so a caller can measure the average pass count over a workload. A caller pulses `start_i` with the operands and then waits for the one-cycle `done_o` pulse. The result and pass count stay on the outputs until the next accepted request or a reset.

Top module: `hacl_adder`

## Requirements
- R1: When `done_o` is high, `sum_o` equals `op_a_i + op_b_i`. The operands are those captured at the accepted start, both zero-extended to `WIDTH+1` bits.
- R2: With `WIDTH=16`, adding 0xFE3A and 0xFC3F produces the 17-bit result 0x1FA79.
- R3: `iter_o` reports the number of half-adder passes taken. This is the number of times the step (x, y) -> (x XOR y, (x AND y) << 1) on `WIDTH+1`-bit words runs before y becomes zero. It never exceeds `WIDTH+1`, and an all-ones operand plus one takes exactly `WIDTH+1` passes.
- R4: If the second operand is zero, the result is reported with `iter_o` = 0 and no pass is run. `done_o` is high in the second cycle after the edge that accepts the start.
- R5: `done_o` is high for exactly one cycle per accepted request, and the controller is idle again in the following cycle.
- R6: A `start_i` pulse that arrives while an addition is in progress is ignored. It produces no extra result and does not change the result of the running addition.
- R7: A synchronous active-high `rst_i` clears `sum_o` and `iter_o` to zero and holds `done_o` low, even when it arrives in the middle of an addition.
- R8: The working registers change only on a load or a pass. Each pass keeps the arithmetic total of the two working words unchanged, and `sum_o` holds its value between a result and the next accepted request.
- R9: An addition that takes P passes raises `done_o` 2P+2 cycles after the clock edge in which the start is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request pulse; sampled only while idle |
| op_a_i | input | WIDTH | First unsigned operand |
| op_b_i | input | WIDTH | Second unsigned operand |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| sum_o | output | WIDTH+1 | Result, held until the next request |
| iter_o | output | $clog2(WIDTH+2) | Half-adder passes taken by the last addition |

## Verification
The bench builds the block with the default `WIDTH` of 16, which makes the fixed 0xFE3A + 0xFC3F case directly checkable. At this width, an all-ones operand plus one drives the pass count to its 17-pass ceiling. The width is small enough that random operand pairs cover a wide range of carry-chain lengths, and each one still completes in a few dozen cycles. The same width also lets the bench inject starts while the block is busy and apply a reset mid-addition, with every latency stated in exact cycles.

// File: rtl/hacl_pkg.sv
package hacl_pkg;

    // Controller states; the order carries no meaning beyond the encoding.
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_PASS = 2'd1,
        ST_TEST = 2'd2,
        ST_DONE = 2'd3
    } hacl_state_e;

endpackage

// File: rtl/hacl_ha_row.sv
// One row of half-adders: bitwise sum and carry word moved up one place.
module hacl_ha_row #(
    parameter int W = 17
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o
);

    assign c_o[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_ha
        assign s_o[i] = x_i[i] ^ y_i[i];
        if (i < W - 1) begin : g_carry
            assign c_o[i+1] = x_i[i] & y_i[i];
        end
    end

endmodule

// File: rtl/hacl_datapath.sv
// Working word pair held in enabled registers, fed back through the row.
module hacl_datapath #(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    output logic [WIDTH:0]   a_o,
    output logic [WIDTH:0]   b_o,
    output logic             b_zero_o
);

    localparam int RW = WIDTH + 1;

    typedef struct packed {
        logic [RW-1:0] a;
        logic [RW-1:0] b;
    } pair_t;

    pair_t         pair_d, pair_q;
    logic [RW-1:0] row_s, row_c;

    hacl_ha_row #(.W(RW)) u_row (
        .x_i (pair_q.a),
        .y_i (pair_q.b),
        .s_o (row_s),
        .c_o (row_c)
    );

    always_comb begin
        pair_d = pair_q;
        if (load_i) begin
            pair_d.a = {1'b0, op_a_i};
            pair_d.b = {1'b0, op_b_i};
        end else if (step_i) begin
            pair_d.a = row_s;
            pair_d.b = row_c;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) pair_q <= '0;
        else       pair_q <= pair_d;
    end

    assign a_o      = pair_q.a;
    assign b_o      = pair_q.b;
    assign b_zero_o = (pair_q.b == '0);

endmodule

// File: rtl/hacl_ctrl.sv
// Four-state sequencer with a pass counter.
module hacl_ctrl
    import hacl_pkg::*;
#(
    parameter int CNTW = 5
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            start_i,
    input  logic            b_zero_i,
    output logic            load_o,
    output logic            step_o,
    output logic            done_o,
    output hacl_state_e     state_o,
    output logic [CNTW-1:0] count_o
);

    typedef struct packed {
        hacl_state_e     st;
        logic [CNTW-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d  = ctl_q;
        load_o = 1'b0;
        step_o = 1'b0;
        case (ctl_q.st)
            ST_WAIT: begin
                if (start_i) begin
                    load_o    = 1'b1;
                    ctl_d.cnt = '0;
                    ctl_d.st  = ST_TEST;
                end
            end
            ST_TEST: ctl_d.st = b_zero_i ? ST_DONE : ST_PASS;
            ST_PASS: begin
                step_o    = 1'b1;
                ctl_d.cnt = ctl_q.cnt + CNTW'(1);
                ctl_d.st  = ST_TEST;
            end
            ST_DONE: ctl_d.st = ST_WAIT;
            default: ctl_d.st = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ctl_q <= '{st: ST_WAIT, cnt: '0};
        else       ctl_q <= ctl_d;
    end

    assign done_o  = (ctl_q.st == ST_DONE);
    assign state_o = ctl_q.st;
    assign count_o = ctl_q.cnt;

endmodule

// File: rtl/hacl_adder.sv
// Top: iterative half-adder adder with start/done handshake.
module hacl_adder
    import hacl_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int RW   = WIDTH + 1,
    localparam int CNTW = $clog2(RW + 1)
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            start_i,
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    output logic            done_o,
    output logic [RW-1:0]   sum_o,
    output logic [CNTW-1:0] iter_o
);

    logic          load, step, b_zero;
    logic [RW-1:0] acc_a, acc_b;
    hacl_state_e   state_q;

    hacl_ctrl #(.CNTW(CNTW)) u_ctrl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .start_i  (start_i),
        .b_zero_i (b_zero),
        .load_o   (load),
        .step_o   (step),
        .done_o   (done_o),
        .state_o  (state_q),
        .count_o  (iter_o)
    );

    hacl_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (load),
        .step_i   (step),
        .op_a_i   (op_a_i),
        .op_b_i   (op_b_i),
        .a_o      (acc_a),
        .b_o      (acc_b),
        .b_zero_o (b_zero)
    );

    assign sum_o = acc_a;

endmodule

// File: rtl/hacl_adder_chk.sv
module hacl_adder_chk
    import hacl_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int RW   = WIDTH + 1,
    localparam int CNTW = $clog2(RW + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            done,
    input hacl_state_e     state,
    input logic [RW-1:0]   a_val,
    input logic [RW-1:0]   b_val,
    input logic [CNTW-1:0] iter
);

    logic [RW:0] total;
    assign total = {1'b0, a_val} + {1'b0, b_val};

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    done_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> (state == ST_WAIT));

    // R3
    iter_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (iter <= CNTW'(RW)));

    // R1
    carry_clear_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (b_val == '0));

    // R8
    total_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PASS) |=> (total == $past(total)));

    // R8
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TEST || state == ST_DONE) |=> ($stable(a_val) && $stable(b_val)));

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && start) |=> (state == ST_WAIT));

endmodule

bind hacl_adder hacl_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk_i),
    .rst   (rst_i),
    .start (start_i),
    .done  (done_o),
    .state (state_q),
    .a_val (acc_a),
    .b_val (acc_b),
    .iter  (iter_o)
);

// File: tb/hacl_adder_test.sv
module hacl_adder_test;

    localparam int W  = 16;
    localparam int RW = W + 1;
    localparam int CW = $clog2(RW + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [W-1:0]  op_a = '0, op_b = '0;
    logic          done_o;
    logic [RW-1:0] sum_o;
    logic [CW-1:0] iter_o;

    hacl_adder #(.WIDTH(W)) uut (
        .clk_i   (clk),
        .rst_i   (rst),
        .start_i (start),
        .op_a_i  (op_a),
        .op_b_i  (op_b),
        .done_o  (done_o),
        .sum_o   (sum_o),
        .iter_o  (iter_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [RW-1:0] sum;
        int            passes;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    logic prev_done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int count_passes(input logic [RW-1:0] x0, input logic [RW-1:0] y0);
        logic [RW-1:0] x, y, t;
        int p;
        x = x0; y = y0; p = 0;
        while (y != '0) begin
            t = x ^ y;
            y = (x & y) << 1;
            x = t;
            p++;
        end
        return p;
    endfunction

    // Monitor: compares each reported result against the scoreboard queue.
    always @(negedge clk) begin
        if (!rst && done_o) begin
            check(!prev_done, "R5", "done longer than one cycle", 1, 0);
            if (q.size() == 0) begin
                check(1'b0, "R6", "result with no pending request", sum_o, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(sum_o == e.sum, "R1", "sum", sum_o, e.sum);
                check(int'(iter_o) == e.passes, "R3", "pass count", iter_o, e.passes);
                check(int'(iter_o) <= RW, "R3", "pass bound", iter_o, RW);
            end
        end
        prev_done <= rst ? 1'b0 : done_o;
    end

    // Driver: pushes expectation, applies start, optionally pokes start while busy.
    task automatic run_add(input logic [W-1:0] av, input logic [W-1:0] bv, input bit poke);
        exp_t e;
        int   lat;
        e.sum    = {1'b0, av} + {1'b0, bv};
        e.passes = count_passes({1'b0, av}, {1'b0, bv});
        q.push_back(e);
        @(negedge clk);
        op_a = av; op_b = bv; start = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 1 && poke) begin
                start = 1'b1; op_a = ~av; op_b = ~bv;  // R6: must be ignored
            end else begin
                start = 1'b0;
            end
        end while (!done_o && lat < 200);
        start = 1'b0;
        check(lat == 2 * e.passes + 2, "R9", "latency", lat, 2 * e.passes + 2);
        if (bv == '0) check(lat == 2, "R4", "zero operand latency", lat, 2);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7 reset state
        check(sum_o == '0, "R7", "sum after reset", sum_o, 0);
        check(iter_o == '0, "R7", "iter after reset", iter_o, 0);
        check(done_o == 1'b0, "R7", "done after reset", done_o, 0);

        // R2 fixed case
        run_add(16'hFE3A, 16'hFC3F, 1'b0);
        check(sum_o == 17'h1FA79, "R2", "fixed sum", sum_o, 17'h1FA79);

        // R3 worst case: all ones plus one
        run_add(16'hFFFF, 16'h0001, 1'b0);
        check(iter_o == CW'(RW), "R3", "all ones plus one passes", iter_o, RW);
        check(sum_o == 17'h10000, "R1", "all ones plus one", sum_o, 17'h10000);

        // R4 zero second operand, and zero plus zero
        run_add(16'hFFFF, 16'h0000, 1'b0);
        check(iter_o == '0, "R4", "no passes", iter_o, 0);
        run_add(16'h0000, 16'h0000, 1'b0);
        run_add(16'h0000, 16'hFFFF, 1'b0);
        run_add(16'hFFFF, 16'hFFFF, 1'b0);

        // R6 starts while busy
        run_add(16'h1234, 16'h0FED, 1'b1);
        run_add(16'h8000, 16'h8000, 1'b1);
        run_add(16'h5555, 16'h0000, 1'b1);

        // R8 result held while idle
        begin
            logic [RW-1:0] held;
            held = sum_o;
            repeat (5) @(negedge clk);
            check(sum_o == held, "R8", "sum held while idle", sum_o, held);
        end

        for (int i = 0; i < 40; i++) begin
            run_add(W'($urandom), W'($urandom), (i % 3) == 0);
        end

        // R7 reset in the middle of an addition
        @(negedge clk);
        op_a = 16'hFFFF; op_b = 16'h0001; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(sum_o == '0, "R7", "sum after mid reset", sum_o, 0);
        check(iter_o == '0, "R7", "iter after mid reset", iter_o, 0);
        rst = 1'b0;
        repeat (40) @(negedge clk);
        check(done_o == 1'b0, "R7", "no done after mid reset", done_o, 0);

        check(q.size() == 0, "R6", "pending results", q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule